// File: doc/BRIEF.md
# Bus Address Decoder with Per-Region Disables

This block sits behind a 32-bit bus master. For each request address it registers a one-hot target select and the offset to pass to that target. It also gives the response code that an internal error region must return. The targets are:

- an external port;
- two error-answering windows;
- interrupt, pin-capture and trace control ports;
- a small wrapped SRAM;
- a pair of SRAM banks that alternate every 1KB.

A run-time disable register can take any internal region out of the map, so that its traffic goes to the external port. The block holds no state machine. The only state is the output register stage and the disable register, and every result is a single registered decode of the request.

Peripheral windows are aliased. The SRAMs wrap at their size. The banked SRAM drops address bit 10, which is the bank bit, before it wraps to the bank size. Error windows return offset zero. External accesses carry the full address.

Top module: `addr_map_decoder`

## Requirements
- R1: After reset, `out_valid` is 0, `out_sel` is all zeros and the disable register holds zero, so every region is enabled.
- R2: A request sampled with `req_valid`=1 at a clock edge gives `out_valid`=1 at that edge with exactly one `out_sel` bit set. A cycle with `req_valid`=0 gives `out_valid`=0 and `out_sel`=0. The select bits are: 0 external, 1 slave-error window, 2 decode-error window, 3 interrupt control, 4 pin capture, 5 trace control, 6 small SRAM, 7 bank 0, 8 bank 1.
- R3: The following ranges select bit 0 with `out_off` equal to the full address and `out_resp`=2'b00:
  - 0x00000000–0x3EFFFFFF
  - 0x3F500000–0x3F6FFFFF
  - 0x40000000–0xCF1FFFFF
  - 0xCF500000–0xFFFFFFFF
- R4: 0x3F000000–0x3F07FFFF selects bit 1 with `out_resp`=2'b10 (slave error) and `out_off`=0.
- R5: Two kinds of address select bit 2 with `out_resp`=2'b11 (decode error) and `out_off`=0:
  - the spare window 0x3F080000–0x3F0FFFFF;
  - the reserved ranges 0x3F300000–0x3F3FFFFF and 0xCF200000–0xCF3FFFFF, which cannot be disabled.
- R6: The peripheral windows have `out_off` equal to address bits 19:0 and `out_resp`=2'b00:
  - 0x3F100000–0x3F1FFFFF selects bit 3;
  - 0x3F200000–0x3F2FFFFF selects bit 4;
  - 0x3F400000–0x3F4FFFFF and 0xCF400000–0xCF4FFFFF both select bit 5.
- R7: 0x3F700000–0x3F7FFFFF selects bit 6 with `out_off` equal to the address modulo `SRAM_BYTES` (16KB by default).
- R8: In 0x3F800000–0x3FFFFFFF, address bit 10 picks bit 7 (0) or bit 8 (1). `out_off` is the address with bit 10 removed, so the higher bits shift down one place, taken modulo `BANK_BYTES` (2MB by default).
- R9: A clock edge with `cfg_we`=1 loads `cfg_wdata` into the disable register. Requests sampled at later edges see the new value. The disable bits are:
  - bit 0: slave-error window
  - bit 1: spare window
  - bit 2: interrupt control
  - bit 3: pin capture
  - bit 4: trace control (both windows)
  - bit 5: small SRAM
  - bit 6: bank pair
- R10: A request to a region whose disable bit is set selects bit 0 with the full address and `out_resp`=2'b00. Disable bits 7–31 have no effect on any decode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Disable register write enable |
| cfg_wdata | input | 32 | Disable register write data |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 32 | Request address |
| out_valid | output | 1 | Registered decode valid |
| out_sel | output | 9 | One-hot target select |
| out_off | output | 32 | Offset presented to the selected target |
| out_resp | output | 2 | Response code the target must return |

## Verification
Every decode result is due exactly one cycle after its request: the select, offset and response register on the edge that samples `req_valid`. The bench therefore drives each request after a falling edge and compares all three outputs at the next falling edge, once the one register stage has been crossed. A disable write takes effect at its own edge, so the bench completes the write cycle before it issues any request that depends on it. The sweeps cover every 512KB window under the all-enabled setting. They also cover the internal 16MB range under each single disable bit, under all disable bits set, and under upper-only disable bits.

// File: rtl/adm_pkg.sv
package adm_pkg;
    typedef enum logic [3:0] {
        T_EXT    = 4'd0,
        T_SLVERR = 4'd1,
        T_DECERR = 4'd2,
        T_IRQC   = 4'd3,
        T_PINCAP = 4'd4,
        T_TRACE  = 4'd5,
        T_SRAM   = 4'd6,
        T_BANK0  = 4'd7,
        T_BANK1  = 4'd8
    } tgt_e;

    localparam int NUM_TGT = 9;
    localparam int DIS_IDX_W = 3;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [1:0] RESP_DECERR = 2'b11;

    localparam logic [DIS_IDX_W-1:0] DIS_DUMMY  = 3'd0;
    localparam logic [DIS_IDX_W-1:0] DIS_SPARE  = 3'd1;
    localparam logic [DIS_IDX_W-1:0] DIS_IRQC   = 3'd2;
    localparam logic [DIS_IDX_W-1:0] DIS_PINCAP = 3'd3;
    localparam logic [DIS_IDX_W-1:0] DIS_TRACE  = 3'd4;
    localparam logic [DIS_IDX_W-1:0] DIS_SRAM   = 3'd5;
    localparam logic [DIS_IDX_W-1:0] DIS_BANKS  = 3'd6;
endpackage

// File: rtl/adm_region_classify.sv
module adm_region_classify
    import adm_pkg::*;
(
    input  logic [31:0]          addr,
    output tgt_e                 raw_tgt,
    output logic                 can_dis,
    output logic [DIS_IDX_W-1:0] dis_idx
);
    always_comb begin
        raw_tgt = T_EXT;
        can_dis = 1'b0;
        dis_idx = DIS_DUMMY;
        if (addr >= 32'h3F00_0000 && addr <= 32'h3F07_FFFF) begin
            raw_tgt = T_SLVERR; can_dis = 1'b1; dis_idx = DIS_DUMMY;
        end else if (addr >= 32'h3F08_0000 && addr <= 32'h3F0F_FFFF) begin
            raw_tgt = T_DECERR; can_dis = 1'b1; dis_idx = DIS_SPARE;
        end else if (addr >= 32'h3F10_0000 && addr <= 32'h3F1F_FFFF) begin
            raw_tgt = T_IRQC;   can_dis = 1'b1; dis_idx = DIS_IRQC;
        end else if (addr >= 32'h3F20_0000 && addr <= 32'h3F2F_FFFF) begin
            raw_tgt = T_PINCAP; can_dis = 1'b1; dis_idx = DIS_PINCAP;
        end else if (addr >= 32'h3F30_0000 && addr <= 32'h3F3F_FFFF) begin
            raw_tgt = T_DECERR;
        end else if ((addr >= 32'h3F40_0000 && addr <= 32'h3F4F_FFFF) ||
                     (addr >= 32'hCF40_0000 && addr <= 32'hCF4F_FFFF)) begin
            raw_tgt = T_TRACE;  can_dis = 1'b1; dis_idx = DIS_TRACE;
        end else if (addr >= 32'h3F70_0000 && addr <= 32'h3F7F_FFFF) begin
            raw_tgt = T_SRAM;   can_dis = 1'b1; dis_idx = DIS_SRAM;
        end else if (addr >= 32'h3F80_0000 && addr <= 32'h3FFF_FFFF) begin
            raw_tgt = addr[10] ? T_BANK1 : T_BANK0;
            can_dis = 1'b1; dis_idx = DIS_BANKS;
        end else if (addr >= 32'hCF20_0000 && addr <= 32'hCF3F_FFFF) begin
            raw_tgt = T_DECERR;
        end
    end
endmodule

// File: rtl/adm_disable_override.sv
module adm_disable_override
    import adm_pkg::*;
#(
    parameter int DIS_W = 32
) (
    input  tgt_e                 raw_tgt,
    input  logic                 can_dis,
    input  logic [DIS_IDX_W-1:0] dis_idx,
    input  logic [DIS_W-1:0]     dis_vec,
    output tgt_e                 fin_tgt,
    output logic [1:0]           fin_resp
);
    logic hit_dis;
    assign hit_dis = can_dis && dis_vec[dis_idx];

    always_comb begin
        fin_tgt = hit_dis ? T_EXT : raw_tgt;
        unique case (fin_tgt)
            T_SLVERR: fin_resp = RESP_SLVERR;
            T_DECERR: fin_resp = RESP_DECERR;
            default:  fin_resp = RESP_OKAY;
        endcase
    end
endmodule

// File: rtl/adm_offset_fold.sv
module adm_offset_fold
    import adm_pkg::*;
#(
    parameter int SRAM_BYTES = 16384,
    parameter int BANK_BYTES = 2097152
) (
    input  tgt_e        tgt,
    input  logic [31:0] addr,
    output logic [31:0] off
);
    localparam logic [31:0] SRAM_MASK = 32'(SRAM_BYTES - 1);
    localparam logic [31:0] BANK_MASK = 32'(BANK_BYTES - 1);
    localparam logic [31:0] PERI_MASK = 32'h000F_FFFF;

    logic [31:0] squeezed;
    assign squeezed = {1'b0, addr[31:11], addr[9:0]};

    always_comb begin
        unique case (tgt)
            T_EXT:                     off = addr;
            T_SLVERR, T_DECERR:        off = '0;
            T_IRQC, T_PINCAP, T_TRACE: off = addr & PERI_MASK;
            T_SRAM:                    off = addr & SRAM_MASK;
            T_BANK0, T_BANK1:          off = squeezed & BANK_MASK;
            default:                   off = addr;
        endcase
    end
endmodule

// File: rtl/addr_map_decoder.sv
module addr_map_decoder
    import adm_pkg::*;
#(
    parameter int SRAM_BYTES = 16384,
    parameter int BANK_BYTES = 2097152,
    parameter int DIS_W      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [DIS_W-1:0]   cfg_wdata,
    input  logic               req_valid,
    input  logic [31:0]        req_addr,
    output logic               out_valid,
    output logic [NUM_TGT-1:0] out_sel,
    output logic [31:0]        out_off,
    output logic [1:0]         out_resp
);
    logic [DIS_W-1:0]     dis_q;
    tgt_e                 raw_tgt;
    tgt_e                 fin_tgt;
    logic                 can_dis;
    logic [DIS_IDX_W-1:0] dis_idx;
    logic [1:0]           resp_d;
    logic [31:0]          off_d;
    logic [NUM_TGT-1:0]   sel_d;

    adm_region_classify u_cls (
        .addr    (req_addr),
        .raw_tgt (raw_tgt),
        .can_dis (can_dis),
        .dis_idx (dis_idx)
    );

    adm_disable_override #(.DIS_W(DIS_W)) u_ovr (
        .raw_tgt  (raw_tgt),
        .can_dis  (can_dis),
        .dis_idx  (dis_idx),
        .dis_vec  (dis_q),
        .fin_tgt  (fin_tgt),
        .fin_resp (resp_d)
    );

    adm_offset_fold #(.SRAM_BYTES(SRAM_BYTES), .BANK_BYTES(BANK_BYTES)) u_off (
        .tgt  (fin_tgt),
        .addr (req_addr),
        .off  (off_d)
    );

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_onehot
        assign sel_d[g] = (fin_tgt == tgt_e'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dis_q <= '0;
        else if (cfg_we) dis_q <= cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sel   <= '0;
            out_off   <= '0;
            out_resp  <= RESP_OKAY;
        end else begin
            out_valid <= req_valid;
            out_sel   <= req_valid ? sel_d  : '0;
            out_off   <= req_valid ? off_d  : '0;
            out_resp  <= req_valid ? resp_d : RESP_OKAY;
        end
    end
endmodule

// File: rtl/adm_checker.sv
module adm_checker #(
    parameter int SRAM_BYTES = 16384,
    parameter int DIS_W      = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [31:0]      req_addr,
    input logic [DIS_W-1:0] dis_q,
    input logic             out_valid,
    input logic [8:0]       out_sel,
    input logic [31:0]      out_off,
    input logic [1:0]       out_resp
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(out_sel) == 1); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_sel == '0); // R2
    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R2
    AST_SLV_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        out_sel[1] |-> (out_resp == 2'b10 && out_off == 32'd0)); // R4
    AST_DEC_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        out_sel[2] |-> (out_resp == 2'b11 && out_off == 32'd0)); // R5
    AST_OK_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sel[1] && !out_sel[2]) |-> out_resp == 2'b00); // R3
    AST_EXT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        out_sel[0] |-> out_off == $past(req_addr)); // R3
    AST_SRAM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_sel[6] |-> out_off < 32'(SRAM_BYTES)); // R7
    AST_BANK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr >= 32'h3F80_0000 && req_addr <= 32'h3FFF_FFFF && req_addr[10])
        |=> (out_sel[8] || out_sel[0])); // R8
    AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dis_q[2] && req_addr[31:20] == 12'h3F1) |=> out_sel[0]); // R10
endmodule

bind addr_map_decoder adm_checker #(.SRAM_BYTES(SRAM_BYTES), .DIS_W(DIS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .dis_q     (dis_q),
    .out_valid (out_valid),
    .out_sel   (out_sel),
    .out_off   (out_off),
    .out_resp  (out_resp)
);

// File: tb/addr_map_decoder_tb.sv
module addr_map_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        out_valid;
    logic [8:0]  out_sel;
    logic [31:0] out_off;
    logic [1:0]  out_resp;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] cur_dis = '0;

    always #2 clk = ~clk;

    addr_map_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .out_valid(out_valid),
        .out_sel(out_sel), .out_off(out_off), .out_resp(out_resp)
    );

    function automatic int exp_tgt(input logic [31:0] a, input logic [31:0] d);
        int t;
        if (a[31:24] == 8'h3F) begin
            case (a[23:20])
                4'h0: t = a[19] ? (d[1] ? 0 : 2) : (d[0] ? 0 : 1);
                4'h1: t = d[2] ? 0 : 3;
                4'h2: t = d[3] ? 0 : 4;
                4'h3: t = 2;
                4'h4: t = d[4] ? 0 : 5;
                4'h5, 4'h6: t = 0;
                4'h7: t = d[5] ? 0 : 6;
                default: t = d[6] ? 0 : (a[10] ? 8 : 7);
            endcase
        end else if (a[31:20] == 12'hCF2 || a[31:20] == 12'hCF3) t = 2;
        else if (a[31:20] == 12'hCF4) t = d[4] ? 0 : 5;
        else t = 0;
        return t;
    endfunction

    function automatic logic [31:0] exp_off(input int t, input logic [31:0] a);
        case (t)
            0: return a;
            1, 2: return 32'd0;
            3, 4, 5: return a % 32'h0010_0000;
            6: return a % 32'd16384;
            default: return (((a >> 11) << 10) + (a % 32'd1024)) % 32'h0020_0000;
        endcase
    endfunction

    function automatic logic [1:0] exp_resp(input int t);
        return (t == 1) ? 2'b10 : (t == 2) ? 2'b11 : 2'b00;
    endfunction

    task automatic check_req(input logic [31:0] a, input string tag);
        int t;
        logic [8:0] es;
        logic [31:0] eo;
        logic [1:0] er;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        t  = exp_tgt(a, cur_dis);
        es = 9'(1 << t);
        eo = exp_off(t, a);
        er = exp_resp(t);
        n_run++;
        if (out_valid !== 1'b1 || out_sel !== es || out_off !== eo || out_resp !== er) begin
            n_fail++;
            $display("FAIL %s addr=%h dis=%h: got v=%b sel=%b off=%h resp=%b exp v=1 sel=%b off=%h resp=%b",
                     tag, a, cur_dis, out_valid, out_sel, out_off, out_resp, es, eo, er);
        end
    endtask

    task automatic write_dis(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        cur_dis = v;
    endtask

    task automatic sweep_internal(input string tag);
        for (int k = 0; k < 2048; k++) begin
            check_req(32'h3F00_0000 + k * 32'h2000 + ((k % 2 == 1) ? 32'h0000_1404 : 32'h0000_03FC), tag);
        end
        check_req(32'hCF40_0010, tag);
        check_req(32'hCF20_0000, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_run++; // R1 reset state
        if (out_valid !== 1'b0 || out_sel !== 9'd0) begin
            n_fail++;
            $display("FAIL R1 reset: got v=%b sel=%b exp v=0 sel=0", out_valid, out_sel);
        end
        check_req(32'h3F10_0000, "R1 all regions enabled after reset");

        // R2 idle cycle gives no select
        @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0 || out_sel !== 9'd0) begin
            n_fail++;
            $display("FAIL R2 idle: got v=%b sel=%b exp v=0 sel=0", out_valid, out_sel);
        end

        // R3 R4 R5 R6 R7 R8 full sweep with all enabled
        for (int k = 0; k < 8192; k++) begin
            check_req(k * 32'h0008_0000, "R2/R3-R8 sweep base");
            check_req(k * 32'h0008_0000 + 32'h0007_FBFC, "R2/R3-R8 sweep high");
        end

        // R7 wrap and R8 interleave corners
        check_req(32'h3F70_4000, "R7 wrap to zero");
        check_req(32'h3F7F_FFFF, "R7 top byte");
        check_req(32'h3F80_03FF, "R8 last byte bank0");
        check_req(32'h3F80_0400, "R8 first byte bank1");
        check_req(32'h3F80_0800, "R8 bank0 second block");
        check_req(32'h3FFF_FFFF, "R8 top of bank1");
        check_req(32'h3EFF_FFFF, "R3 edge below internal");
        check_req(32'h4000_0000, "R3 edge above internal");
        check_req(32'hCF1F_FFFF, "R3 edge below reserved");
        check_req(32'hCF50_0000, "R3 edge above trace alias");

        // R9 R10 each disable bit alone
        for (int b = 0; b < 7; b++) begin
            write_dis(32'(1) << b);
            sweep_internal("R9/R10 single disable");
        end
        write_dis(32'h0000_007F);
        sweep_internal("R10 all disabled");
        write_dis(32'hFFFF_FF80);
        sweep_internal("R10 upper bits no effect");
        write_dis(32'h0000_0000);
        check_req(32'h3F00_0000, "R9 re-enabled dummy");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule